// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Controller

This block steers operands and holds the front end of a five-stage, in-order, 64-bit integer pipeline. It takes the full 32-bit instruction words held in the fetch/decode, decode/execute, execute/memory and memory/writeback pipeline registers. It decodes the register fields and opcodes of these words directly and produces two things. The first is a pair of 2-bit source codes for the two ALU inputs. The second is an interlock that stops the program counter and the fetch/decode register and turns the next decode/execute entry into a no-op.

The block contains no datapath. The register file, the ALU, the memories and branch resolution sit around it. The surrounding pipeline uses `sel_a_o` and `sel_b_o` to drive its operand multiplexers, and uses the write-enable and bubble outputs to drive its pipeline registers. The only state is an optional flag that records whether the previous cycle stalled. With this flag, a stall never lasts longer than one cycle in a row.

Top module: `fwd_hazard_ctrl`

## Requirements
- R1: Fields are taken from fixed bit positions of each instruction word: opcode at [6:0], destination at [11:7], first source at [19:15], second source at [24:20]. `sel_a_o` is derived only from the decode/execute first source, and `sel_b_o` is derived only from its second source.
- R2: A source code of 2'b10 (execute/memory result) is produced when the execute/memory opcode is 7'b0010011 (ALU-immediate) and its destination equals the consuming source register.
- R3: A source code of 2'b01 (writeback value) is produced when the memory/writeback opcode is 7'b0010011 or 7'b0000011 (load), its destination equals the consuming source register, and R2 does not apply.
- R4: A source register of x0 (index 0) always yields code 2'b00, whatever the later stages hold.
- R5: When both later stages match, code 2'b10 wins over 2'b01. Code 2'b11 is never produced, and 2'b00 means the register-read value.
- R6: An execute/memory instruction that is a load (7'b0000011), a store (7'b0100011) or a register-form ALU operation (7'b0110011) never yields code 2'b10.
- R7: `stall_o` is asserted when the decode/execute opcode is a load with a nonzero destination that equals the fetch/decode first source.
- R8: A match on the fetch/decode second source causes a stall only when the fetch/decode opcode is 7'b0110011 or 7'b0100011. For any other opcode, the second-source field is ignored.
- R9: A load whose destination is x0 never causes a stall.
- R10: While `stall_o` is high, `pc_we_o` and `ifid_we_o` are low and `idex_bubble_o` is high. Otherwise these outputs are the reverse. `nop_word_o` is always 32'h0000_0013.
- R11: With ONE_SHOT set (the default), `stall_o` is never high in two consecutive cycles. A stall condition that persists is answered again in the cycle after.
- R12: After reset, the stall-history flag is clear. With no-op words in every stage, both codes are 2'b00 and there is no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the stall-history flag |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ifid_instr_i | input | 32 | Instruction word in fetch/decode |
| idex_instr_i | input | 32 | Instruction word in decode/execute |
| exmem_instr_i | input | 32 | Instruction word in execute/memory |
| memwb_instr_i | input | 32 | Instruction word in memory/writeback |
| sel_a_o | output | 2 | Source code for ALU input A |
| sel_b_o | output | 2 | Source code for ALU input B |
| stall_o | output | 1 | Load-use interlock active |
| pc_we_o | output | 1 | Program counter write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| idex_bubble_o | output | 1 | Load the no-op word into decode/execute |
| nop_word_o | output | 32 | Encoding to inject as the bubble |

## Verification
The assertions assume that the instruction words stay stable between clock edges and that the surrounding pipeline obeys the interlock. In practice, this means a stalled load moves on out of decode/execute in the cycle that follows. The one-shot property depends on that behaviour. The stimulus follows it by placing a non-load in decode/execute after every stall cycle, with one exception: a deliberate hold of the same load-use pair for three cycles, which exercises the one-shot flag itself. Source operands are taken from register-form instructions in decode/execute, so that the second-source field carries a real register index.

// File: rtl/fwd_hazard_pkg.sv
`timescale 1ns/1ps
package fwd_hazard_pkg;
  localparam int INSTR_W = 32;
  localparam int RADDR_W = 5;
  localparam int OPC_W   = 7;

  localparam int OPC_LSB = 0;
  localparam int RD_LSB  = 7;
  localparam int RS1_LSB = 15;
  localparam int RS2_LSB = 20;

  localparam logic [OPC_W-1:0] OPC_ALU_IMM = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_ALU_REG = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_LOAD    = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE   = 7'b0100011;

  localparam logic [INSTR_W-1:0] NOP_WORD = 32'h0000_0013;

  typedef enum logic [1:0] {
    SRC_REG = 2'b00,
    SRC_WB  = 2'b01,
    SRC_EXM = 2'b10
  } src_sel_e;

  typedef struct packed {
    logic [OPC_W-1:0]   opc;
    logic [RADDR_W-1:0] rd;
    logic [RADDR_W-1:0] rs1;
    logic [RADDR_W-1:0] rs2;
  } instr_fields_t;
endpackage

// File: rtl/fwd_stage_decode.sv
`timescale 1ns/1ps
module fwd_stage_decode
  import fwd_hazard_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output instr_fields_t      fields_o
);
  localparam int FN3_LSB = RD_LSB + RADDR_W;
  localparam int FN7_LSB = RS2_LSB + RADDR_W;

  assign fields_o.opc = instr_i[OPC_LSB +: OPC_W];
  assign fields_o.rd  = instr_i[RD_LSB  +: RADDR_W];
  assign fields_o.rs1 = instr_i[RS1_LSB +: RADDR_W];
  assign fields_o.rs2 = instr_i[RS2_LSB +: RADDR_W];

  logic unused_bits;
  assign unused_bits = ^{instr_i[INSTR_W-1:FN7_LSB], instr_i[RS1_LSB-1:FN3_LSB]};
endmodule

// File: rtl/fwd_operand_sel.sv
`timescale 1ns/1ps
module fwd_operand_sel
  import fwd_hazard_pkg::*;
(
  input  logic [RADDR_W-1:0] src_i,
  input  logic [RADDR_W-1:0] exm_rd_i,
  input  logic               exm_prod_i,
  input  logic [RADDR_W-1:0] wb_rd_i,
  input  logic               wb_prod_i,
  output src_sel_e           sel_o
);
  logic src_live, hit_exm, hit_wb;

  assign src_live = |src_i;
  assign hit_exm  = src_live && exm_prod_i && (exm_rd_i == src_i);
  assign hit_wb   = src_live && wb_prod_i  && (wb_rd_i  == src_i);

  // nearer producer carries the younger value
  always_comb begin
    if (hit_exm)     sel_o = SRC_EXM;
    else if (hit_wb) sel_o = SRC_WB;
    else             sel_o = SRC_REG;
  end
endmodule

// File: rtl/fwd_load_use_detect.sv
`timescale 1ns/1ps
module fwd_load_use_detect
  import fwd_hazard_pkg::*;
#(
  parameter bit ONE_SHOT = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  instr_fields_t prod_i,
  input  instr_fields_t cons_i,
  output logic          stall_o
);
  logic prod_is_load, cons_reads_rs2, hit_rs1, hit_rs2, stall_raw;

  assign prod_is_load   = (prod_i.opc == OPC_LOAD) && (|prod_i.rd);
  assign cons_reads_rs2 = (cons_i.opc == OPC_ALU_REG) || (cons_i.opc == OPC_STORE);
  assign hit_rs1        = (prod_i.rd == cons_i.rs1);
  assign hit_rs2        = cons_reads_rs2 && (prod_i.rd == cons_i.rs2);
  assign stall_raw      = prod_is_load && (hit_rs1 || hit_rs2);

  logic unused_fields;
  assign unused_fields = ^{prod_i.rs1, prod_i.rs2, cons_i.rd};

  if (ONE_SHOT) begin : g_one_shot
    logic stall_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stall_q <= 1'b0;
      else         stall_q <= stall_o;
    end
    assign stall_o = stall_raw && !stall_q;
  end else begin : g_plain
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign stall_o    = stall_raw;
  end
endmodule

// File: rtl/fwd_hazard_ctrl.sv
`timescale 1ns/1ps
module fwd_hazard_ctrl
  import fwd_hazard_pkg::*;
#(
  parameter bit ONE_SHOT = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] ifid_instr_i,
  input  logic [INSTR_W-1:0] idex_instr_i,
  input  logic [INSTR_W-1:0] exmem_instr_i,
  input  logic [INSTR_W-1:0] memwb_instr_i,
  output logic [1:0]         sel_a_o,
  output logic [1:0]         sel_b_o,
  output logic               stall_o,
  output logic               pc_we_o,
  output logic               ifid_we_o,
  output logic               idex_bubble_o,
  output logic [INSTR_W-1:0] nop_word_o
);
  localparam int NUM_STAGES = 4;
  localparam int ST_IFID = 0;
  localparam int ST_IDEX = 1;
  localparam int ST_EXM  = 2;
  localparam int ST_WB   = 3;
  localparam int NUM_OPND = 2;

  logic [INSTR_W-1:0] stage_instr [NUM_STAGES];
  instr_fields_t      stage_f     [NUM_STAGES];

  assign stage_instr[ST_IFID] = ifid_instr_i;
  assign stage_instr[ST_IDEX] = idex_instr_i;
  assign stage_instr[ST_EXM]  = exmem_instr_i;
  assign stage_instr[ST_WB]   = memwb_instr_i;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_dec
    fwd_stage_decode u_dec (
      .instr_i  (stage_instr[g]),
      .fields_o (stage_f[g])
    );
  end

  logic exm_prod, wb_prod;
  assign exm_prod = (stage_f[ST_EXM].opc == OPC_ALU_IMM);
  assign wb_prod  = (stage_f[ST_WB].opc == OPC_ALU_IMM) || (stage_f[ST_WB].opc == OPC_LOAD);

  logic [RADDR_W-1:0] opnd_src [NUM_OPND];
  src_sel_e           opnd_sel [NUM_OPND];

  assign opnd_src[0] = stage_f[ST_IDEX].rs1;
  assign opnd_src[1] = stage_f[ST_IDEX].rs2;

  for (genvar k = 0; k < NUM_OPND; k++) begin : g_opnd
    fwd_operand_sel u_sel (
      .src_i      (opnd_src[k]),
      .exm_rd_i   (stage_f[ST_EXM].rd),
      .exm_prod_i (exm_prod),
      .wb_rd_i    (stage_f[ST_WB].rd),
      .wb_prod_i  (wb_prod),
      .sel_o      (opnd_sel[k])
    );
  end

  assign sel_a_o = opnd_sel[0];
  assign sel_b_o = opnd_sel[1];

  fwd_load_use_detect #(.ONE_SHOT(ONE_SHOT)) u_lu (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .prod_i  (stage_f[ST_IDEX]),
    .cons_i  (stage_f[ST_IFID]),
    .stall_o (stall_o)
  );

  assign pc_we_o       = !stall_o;
  assign ifid_we_o     = !stall_o;
  assign idex_bubble_o = stall_o;
  assign nop_word_o    = NOP_WORD;

  logic unused_fields;
  assign unused_fields = ^{stage_f[ST_EXM].rs1, stage_f[ST_EXM].rs2,
                           stage_f[ST_WB].rs1,  stage_f[ST_WB].rs2};
endmodule

// File: rtl/fwd_hazard_ctrl_chk.sv
`timescale 1ns/1ps
module fwd_hazard_ctrl_chk
  import fwd_hazard_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [INSTR_W-1:0] idex_instr_i,
  input logic [INSTR_W-1:0] exmem_instr_i,
  input logic [INSTR_W-1:0] memwb_instr_i,
  input logic [1:0]         sel_a_o,
  input logic [1:0]         sel_b_o,
  input logic               stall_o,
  input logic               pc_we_o,
  input logic               ifid_we_o,
  input logic               idex_bubble_o
);
  logic [RADDR_W-1:0] c_rs1, c_rs2, x_rd, w_rd, l_rd;
  logic [OPC_W-1:0]   x_op, w_op, l_op;
  assign c_rs1 = idex_instr_i[19:15];
  assign c_rs2 = idex_instr_i[24:20];
  assign l_rd  = idex_instr_i[11:7];
  assign l_op  = idex_instr_i[6:0];
  assign x_rd  = exmem_instr_i[11:7];
  assign x_op  = exmem_instr_i[6:0];
  assign w_rd  = memwb_instr_i[11:7];
  assign w_op  = memwb_instr_i[6:0];

  logic unused_bits;
  assign unused_bits = ^{idex_instr_i[31:25], idex_instr_i[14:12],
                         exmem_instr_i[31:12], memwb_instr_i[31:12]};

  p_x0_a_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_rs1 == '0) |-> (sel_a_o == 2'b00));
  p_x0_b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_rs2 == '0) |-> (sel_b_o == 2'b00));
  p_code_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_a_o != 2'b11) && (sel_b_o != 2'b11));
  p_exm_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_op == OPC_ALU_IMM && x_rd == c_rs1 && c_rs1 != '0) |-> (sel_a_o == 2'b10));
  p_wb_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_rd != c_rs2 && w_op == OPC_LOAD && w_rd == c_rs2 && c_rs2 != '0) |-> (sel_b_o == 2'b01));
  p_no_exm_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_op == OPC_LOAD) |-> (sel_a_o != 2'b10 && sel_b_o != 2'b10));
  p_no_stall_x0_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_op == OPC_LOAD && l_rd == '0) |-> !stall_o);
  p_stall_ctrl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (!pc_we_o && !ifid_we_o && idex_bubble_o));
  p_run_ctrl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_o |-> (pc_we_o && ifid_we_o && !idex_bubble_o));
  p_one_shot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o);
endmodule

bind fwd_hazard_ctrl fwd_hazard_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .idex_instr_i  (idex_instr_i),
  .exmem_instr_i (exmem_instr_i),
  .memwb_instr_i (memwb_instr_i),
  .sel_a_o       (sel_a_o),
  .sel_b_o       (sel_b_o),
  .stall_o       (stall_o),
  .pc_we_o       (pc_we_o),
  .ifid_we_o     (ifid_we_o),
  .idex_bubble_o (idex_bubble_o)
);

// File: tb/fwd_hazard_ctrl_test.sv
`timescale 1ns/1ps
module fwd_hazard_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ifid_instr_i, idex_instr_i, exmem_instr_i, memwb_instr_i;
  logic [1:0]  sel_a_o, sel_b_o;
  logic        stall_o, pc_we_o, ifid_we_o, idex_bubble_o;
  logic [31:0] nop_word_o;

  localparam logic [31:0] NOP = 32'h0000_0013;

  always #4 clk_i = ~clk_i;

  fwd_hazard_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ifid_instr_i(ifid_instr_i), .idex_instr_i(idex_instr_i),
    .exmem_instr_i(exmem_instr_i), .memwb_instr_i(memwb_instr_i),
    .sel_a_o(sel_a_o), .sel_b_o(sel_b_o), .stall_o(stall_o),
    .pc_we_o(pc_we_o), .ifid_we_o(ifid_we_o), .idex_bubble_o(idex_bubble_o),
    .nop_word_o(nop_word_o)
  );

  typedef struct {
    logic [1:0] a;
    logic [1:0] b;
    logic       st;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  function automatic logic [31:0] alui(input logic [4:0] rd, rs1);
    return {12'd0, rs1, 3'b000, rd, 7'b0010011};
  endfunction
  function automatic logic [31:0] alur(input logic [4:0] rd, rs1, rs2);
    return {7'd0, rs2, rs1, 3'b000, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] ld(input logic [4:0] rd, rs1);
    return {12'd0, rs1, 3'b011, rd, 7'b0000011};
  endfunction
  function automatic logic [31:0] st(input logic [4:0] rs2, rs1, imm_lo);
    return {7'd0, rs2, rs1, 3'b011, imm_lo, 7'b0100011};
  endfunction

  task automatic drive(input logic [31:0] f, d, e, m,
                       input logic [1:0] a, b, input logic s, input string tag);
    exp_t it;
    @(posedge clk_i);
    #1;
    ifid_instr_i  = f;
    idex_instr_i  = d;
    exmem_instr_i = e;
    memwb_instr_i = m;
    it.a = a; it.b = b; it.st = s; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic cmp(input logic [31:0] act, exp, input string what, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      cmp({30'd0, sel_a_o}, {30'd0, it.a}, "sel_a", it.tag);
      cmp({30'd0, sel_b_o}, {30'd0, it.b}, "sel_b", it.tag);
      cmp({31'd0, stall_o}, {31'd0, it.st}, "stall", it.tag);
      cmp({29'd0, pc_we_o, ifid_we_o, idex_bubble_o},
          {29'd0, !it.st, !it.st, it.st}, "R10 we/bubble", it.tag);
      cmp(nop_word_o, NOP, "R10 nop_word", it.tag);
    end
  end

  initial begin
    ifid_instr_i = NOP; idex_instr_i = NOP; exmem_instr_i = NOP; memwb_instr_i = NOP;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R12 reset state, no-ops everywhere
    drive(NOP, NOP, NOP, NOP, 2'b00, 2'b00, 1'b0, "R12");
    // R2 back-to-back ALU dependency on A, then on B (R1 independence)
    drive(NOP, alur(5,1,2), alui(1,3), NOP, 2'b10, 2'b00, 1'b0, "R2/R1 A");
    drive(NOP, alur(5,1,2), alui(2,3), NOP, 2'b00, 2'b10, 1'b0, "R2/R1 B");
    // R3 distance-two from ALU and from load
    drive(NOP, alur(5,1,2), NOP, alui(1,7), 2'b01, 2'b00, 1'b0, "R3 alu");
    drive(NOP, alur(5,1,2), NOP, ld(2,7),   2'b00, 2'b01, 1'b0, "R3 load");
    // R6 non-producers in execute/memory
    drive(NOP, alur(5,1,2), ld(1,3),     NOP, 2'b00, 2'b00, 1'b0, "R6 load");
    drive(NOP, alur(5,1,2), st(4,3,1),   NOP, 2'b00, 2'b00, 1'b0, "R6 store");
    drive(NOP, alur(5,1,2), alur(2,3,4), NOP, 2'b00, 2'b00, 1'b0, "R6 regform");
    // R5 both stages match; split A/B
    drive(NOP, alur(5,1,2), alui(1,3), alui(1,4), 2'b10, 2'b00, 1'b0, "R5 prio");
    drive(NOP, alur(5,1,2), alui(1,3), ld(2,4),   2'b10, 2'b01, 1'b0, "R5 split");
    // R4 x0 dependency
    drive(NOP, alur(5,0,0), alui(0,3), alui(0,4), 2'b00, 2'b00, 1'b0, "R4");
    // R7 load-use on first source
    drive(alui(7,4), ld(4,1), NOP, NOP, 2'b00, 2'b00, 1'b1, "R7");
    drive(alui(7,4), NOP,     NOP, NOP, 2'b00, 2'b00, 1'b0, "R7 after");
    // R8 second source: register form, store, ignored for immediate form
    drive(alur(7,1,4), ld(4,1), NOP, NOP, 2'b00, 2'b00, 1'b1, "R8 regform");
    drive(NOP,         NOP,     NOP, NOP, 2'b00, 2'b00, 1'b0, "R8 gap");
    drive(st(4,1,0),   ld(4,1), NOP, NOP, 2'b00, 2'b00, 1'b1, "R8 store");
    drive(NOP,         NOP,     NOP, NOP, 2'b00, 2'b00, 1'b0, "R8 gap");
    drive({7'd0, 5'd4, 5'd1, 3'b000, 5'd7, 7'b0010011}, ld(4,1), NOP, NOP,
          2'b00, 2'b00, 1'b0, "R8 imm");
    // R9 load to x0
    drive(alui(7,0), ld(0,1), NOP, NOP, 2'b00, 2'b00, 1'b0, "R9");
    // R11 persistent load-use pair
    drive(alui(7,4), ld(4,1), NOP, NOP, 2'b00, 2'b00, 1'b1, "R11 first");
    drive(alui(7,4), ld(4,1), NOP, NOP, 2'b00, 2'b00, 1'b0, "R11 second");
    drive(alui(7,4), ld(4,1), NOP, NOP, 2'b00, 2'b00, 1'b1, "R11 third");
    drive(NOP, NOP, NOP, NOP, 2'b00, 2'b00, 1'b0, "R11 drain");

    repeat (3) @(posedge clk_i);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL R12 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule